// File: doc/BRIEF.md
# SRAM page address selector

This block forms the physical data-memory address for an 8-bit processor whose SRAM is divided into 256-byte pages. The core hands it an 8-bit offset, a code naming the kind of access in progress, and the two paging-mode bits of its flag register. The block returns an 11-bit address: a 3-bit page number above the unchanged offset.

The page comes from one of four small pointer registers, or is forced to page 0. The rule depends on the access class:
- Stack traffic always follows the stack page.
- Indirect-read data always follows the indirect-read page.
- Indexed accesses are steered by the mode bits to page 0, the index page or the stack page.
- Direct accesses and the indirect pointer fetch use the current page, or page 0 when paging is off.

Software sets the pointers through a byte-wide register port. Writes take effect from the next clock edge, so the next access already sees the new page. The address path itself is purely combinational.

Top module: `sram_page_sel`

## Requirements
- R1: After reset, every page pointer (stack 0xD1, index 0xD3, indirect-read 0xD4, current 0xD0) reads back as 0x00.
- R2: A write with `reg_wr`=1 and `reg_bank`=0 to one of those addresses stores `reg_wdata[2:0]`. A read returns that value in bits [2:0] with bits [7:3] zero. Writes with `reg_bank`=1, or to any other address, change no pointer, and reads of other addresses return 0x00.
- R3: Stack accesses (`acc_kind`=3'd1) use the stack page for every value of `flag_pg`.
- R4: A stack-pointer write applies to the first stack access after the clock edge that takes the write, with no extra delay.
- R5: Source-indexed (3'd2) and destination-indexed (3'd3) accesses use the index page when `flag_pg`=2'b10.
- R6: Indexed accesses use the stack page when `flag_pg`=2'b11.
- R7: Indexed accesses use page 0 when `flag_pg` is 2'b00 or 2'b01.
- R8: The indirect pointer fetch (3'd4) uses the same page as a direct access: page 0 when `flag_pg`=2'b00, otherwise the current page.
- R9: Indirect-read data (3'd5) uses the indirect-read page for every value of `flag_pg`.
- R10: Direct accesses (3'd0) use page 0 when `flag_pg`=2'b00 and the current page for any other mode.
- R11: `sram_addr` equals {page[2:0], `acc_offset`[7:0]} and follows its inputs in the same cycle.
- R12: The unused access codes 3'd6 and 3'd7 use page 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_bank | input | 1 | Register bank select; pointers live in bank 0 |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`/`reg_bank` |
| acc_kind | input | 3 | Access class: 0 direct, 1 stack, 2 src-indexed, 3 dst-indexed, 4 pointer fetch, 5 indirect data |
| flag_pg | input | 2 | Paging-mode bits from the flag register |
| acc_offset | input | 8 | Byte offset within the page |
| sram_addr | output | 11 | Physical SRAM address {page, offset} |

## Verification
The bench builds the block with its default parameters: a 3-bit page over an 8-bit offset and the four pointer addresses 0xD0, 0xD1, 0xD3 and 0xD4. With these values, every access class can be crossed with all four paging modes against distinct nonzero pages, so a wrong selection always shows as a wrong page. Writing 0xFF then shows that only the low three bits are kept. The pages are small enough that the highest page (7) and the offset extremes 0x00 and 0xFF are also covered.

// File: rtl/sram_page_sel.sv
module sram_page_sel #(
  parameter int PAGE_W   = 3,
  parameter int OFS_W    = 8,
  parameter int RBUS_W   = 8,
  parameter int KIND_W   = 3,
  parameter logic [RBUS_W-1:0] CUR_RA = 8'hD0,
  parameter logic [RBUS_W-1:0] STK_RA = 8'hD1,
  parameter logic [RBUS_W-1:0] IDX_RA = 8'hD3,
  parameter logic [RBUS_W-1:0] IRD_RA = 8'hD4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_bank,
  input  logic [RBUS_W-1:0]         reg_addr,
  input  logic [RBUS_W-1:0]         reg_wdata,
  output logic [RBUS_W-1:0]         reg_rdata,
  input  logic [KIND_W-1:0]         acc_kind,
  input  logic [1:0]                flag_pg,
  input  logic [OFS_W-1:0]          acc_offset,
  output logic [PAGE_W+OFS_W-1:0]   sram_addr
);

  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int PAD_W  = RBUS_W - PAGE_W;

  localparam logic [KIND_W-1:0] K_DIR  = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_STK  = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_SIDX = KIND_W'(2);
  localparam logic [KIND_W-1:0] K_DIDX = KIND_W'(3);
  localparam logic [KIND_W-1:0] K_IPTR = KIND_W'(4);
  localparam logic [KIND_W-1:0] K_IRD  = KIND_W'(5);

  logic [PAGE_W-1:0] cur_pg, stk_pg, idx_pg, ird_pg;
  logic [PAGE_W-1:0] dir_pg, ix_pg, sel_pg;

  wire bank0  = ~reg_bank;
  wire wr_cur = reg_wr & bank0 & (reg_addr == CUR_RA);
  wire wr_stk = reg_wr & bank0 & (reg_addr == STK_RA);
  wire wr_idx = reg_wr & bank0 & (reg_addr == IDX_RA);
  wire wr_ird = reg_wr & bank0 & (reg_addr == IRD_RA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pg <= '0;
      stk_pg <= '0;
      idx_pg <= '0;
      ird_pg <= '0;
    end else begin
      if (wr_cur) cur_pg <= reg_wdata[PAGE_W-1:0];
      if (wr_stk) stk_pg <= reg_wdata[PAGE_W-1:0];
      if (wr_idx) idx_pg <= reg_wdata[PAGE_W-1:0];
      if (wr_ird) ird_pg <= reg_wdata[PAGE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (bank0) begin
      unique case (reg_addr)
        CUR_RA:  reg_rdata = {{PAD_W{1'b0}}, cur_pg};
        STK_RA:  reg_rdata = {{PAD_W{1'b0}}, stk_pg};
        IDX_RA:  reg_rdata = {{PAD_W{1'b0}}, idx_pg};
        IRD_RA:  reg_rdata = {{PAD_W{1'b0}}, ird_pg};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign dir_pg = (flag_pg == 2'b00) ? '0 : cur_pg;

  always_comb begin
    unique case (flag_pg)
      2'b10:   ix_pg = idx_pg;
      2'b11:   ix_pg = stk_pg;
      default: ix_pg = '0;
    endcase
  end

  always_comb begin
    unique case (acc_kind)
      K_DIR, K_IPTR:  sel_pg = dir_pg;
      K_STK:          sel_pg = stk_pg;
      K_SIDX, K_DIDX: sel_pg = ix_pg;
      K_IRD:          sel_pg = ird_pg;
      default:        sel_pg = '0;
    endcase
  end

  assign sram_addr = {sel_pg, acc_offset};

  wire is_ix = (acc_kind == K_SIDX) || (acc_kind == K_DIDX);
  wire [PAGE_W-1:0] out_pg = sram_addr[ADDR_W-1:OFS_W];

  // R4
  stk_write_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stk |=> (acc_kind != K_STK || out_pg == $past(reg_wdata[PAGE_W-1:0])));

  // R5
  idx_write_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (!is_ix || flag_pg != 2'b10 || out_pg == $past(reg_wdata[PAGE_W-1:0])));

  // R9
  ird_write_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ird |=> (acc_kind != K_IRD || out_pg == $past(reg_wdata[PAGE_W-1:0])));

  // R7
  ix_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ix && !flag_pg[1]) |-> (out_pg == '0));

  // R11
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_addr[OFS_W-1:0] == acc_offset);

  // R2
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RBUS_W-1:PAGE_W] == '0);

endmodule

// File: tb/sram_page_sel_test.sv
module sram_page_sel_test;
  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0, reg_bank = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [2:0] acc_kind = 0;
  logic [1:0] flag_pg = 0;
  logic [7:0] acc_offset = 0;
  logic [10:0] sram_addr;
  int applied = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_page_sel uut (.clk, .rst_n, .reg_wr, .reg_bank, .reg_addr, .reg_wdata,
    .reg_rdata, .acc_kind, .flag_pg, .acc_offset, .sram_addr);

  // entry: {kind[2:0], mode[1:0], offset[7:0], expected[10:0]}
  // pages loaded: cur=2, stk=5, idx=3, ird=6
  localparam logic [23:0] VEC [20] = '{
    {3'd0, 2'd0, 8'h12, 11'h012},  // R10
    {3'd0, 2'd1, 8'h34, 11'h234},  // R10
    {3'd0, 2'd2, 8'h56, 11'h256},  // R10
    {3'd0, 2'd3, 8'hFF, 11'h2FF},  // R10 R11
    {3'd1, 2'd0, 8'h00, 11'h500},  // R3 R11
    {3'd1, 2'd2, 8'h7F, 11'h57F},  // R3
    {3'd1, 2'd3, 8'h80, 11'h580},  // R3
    {3'd2, 2'd0, 8'h11, 11'h011},  // R7
    {3'd2, 2'd1, 8'h22, 11'h022},  // R7
    {3'd2, 2'd2, 8'h33, 11'h333},  // R5
    {3'd3, 2'd2, 8'h44, 11'h344},  // R5
    {3'd3, 2'd3, 8'h55, 11'h555},  // R6
    {3'd2, 2'd3, 8'h66, 11'h566},  // R6
    {3'd4, 2'd0, 8'h77, 11'h077},  // R8
    {3'd4, 2'd1, 8'h88, 11'h288},  // R8
    {3'd5, 2'd0, 8'h99, 11'h699},  // R9
    {3'd5, 2'd3, 8'hAA, 11'h6AA},  // R9
    {3'd6, 2'd1, 8'hBB, 11'h0BB},  // R12
    {3'd7, 2'd3, 8'hCC, 11'h0CC},  // R12
    {3'd3, 2'd1, 8'hDD, 11'h0DD}   // R7
  };

  function automatic string tag_of(input logic [2:0] k, input logic [1:0] m);
    case (k)
      3'd0: return "R10";
      3'd1: return "R3";
      3'd2, 3'd3: return (m == 2'b10) ? "R5" : (m == 2'b11) ? "R6" : "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_bank = bank; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_bank = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_bank = 0; reg_addr = a;
    #1 check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic acc(input string req, input logic [2:0] k, input logic [1:0] m,
                     input logic [7:0] o, input logic [10:0] exp);
    acc_kind = k; flag_pg = m; acc_offset = o;
    #1 check(req, {21'd0, sram_addr}, {21'd0, exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; applied++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd("R1", 8'hD0, 8'h00);
    rd("R1", 8'hD1, 8'h00);
    rd("R1", 8'hD3, 8'h00);
    rd("R1", 8'hD4, 8'h00);
    @(negedge clk);
    acc("R1", 3'd5, 2'd0, 8'h10, 11'h010);

    wr(0, 8'hD0, 8'h02);
    wr(0, 8'hD1, 8'h05);
    wr(0, 8'hD3, 8'h03);
    wr(0, 8'hD4, 8'h06);
    rd("R2", 8'hD0, 8'h02);
    rd("R2", 8'hD1, 8'h05);
    rd("R2", 8'hD3, 8'h03);
    rd("R2", 8'hD4, 8'h06);

    @(negedge clk);
    foreach (VEC[i]) begin
      acc(tag_of(VEC[i][23:21], VEC[i][20:19]), VEC[i][23:21], VEC[i][20:19],
          VEC[i][18:11], VEC[i][10:0]);
      #2;
    end

    // R2 ignored writes: other bank, unmapped address
    wr(1, 8'hD1, 8'h07);
    rd("R2", 8'hD1, 8'h05);
    wr(0, 8'hD2, 8'h07);
    rd("R2", 8'hD2, 8'h00);
    rd("R2", 8'hD0, 8'h02);
    rd("R2", 8'hD3, 8'h03);
    rd("R2", 8'hD4, 8'h06);
    @(negedge clk);
    reg_bank = 1; reg_addr = 8'hD1;
    #1 check("R2", {24'd0, reg_rdata}, 32'd0);
    reg_bank = 0;
    // R2 upper bits dropped
    wr(0, 8'hD4, 8'hFF);
    rd("R2", 8'hD4, 8'h07);
    acc("R9", 3'd5, 2'd1, 8'h01, 11'h701);

    // R4 stack pointer change visible on the next stack access
    @(negedge clk);
    acc_kind = 3'd1; flag_pg = 2'd2; acc_offset = 8'h40;
    reg_wr = 1; reg_addr = 8'hD1; reg_wdata = 8'h01;
    #1 check("R4", {21'd0, sram_addr}, {21'd0, 11'h540});
    @(negedge clk);
    reg_wr = 0;
    #1 check("R4", {21'd0, sram_addr}, {21'd0, 11'h140});
    acc("R6", 3'd3, 2'd3, 8'h41, 11'h141);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule